// File: doc/BRIEF.md
# Exponential Collision Backoff Generator

This block decides how long a station on a shared 10 Mb/s medium waits before it retries a frame that collided. A 17-bit pseudo-random sequence advances on every bit-time enable and never stops. When a collision is reported, the block takes the sequence value at that moment and keeps only its lowest k bits. The width k grows with the number of consecutive collisions and stops growing at ten. The kept value is the number of slot times to wait. A prescaler counts bit-time enables into slots, and each full slot lowers the remaining count by one.

The transmit controller pulses the collision input and presents the current consecutive-collision number. It then waits for the done pulse before it retries. When a frame succeeds, the controller raises the clear input, which drops any countdown in progress. Carrier sensing, frame transmission and the bookkeeping of the collision number are handled outside this block.

Top module: `backoff_gen`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `busy` and `done` are both 0.
- R2: The random state is a 17-bit Fibonacci LFSR. Its next value is `{s[15:0], s[16]^s[13]}` and its reset value is the nonzero `SEED` parameter (default 1). It advances only in cycles where `bit_en` is 1, and it never holds the value zero.
- R3: A capture happens in a cycle where the block is idle and `coll`=1, `bit_en`=1 and `clr`=0. The capture takes the LFSR value of that cycle, before that cycle's advance, and keeps its lowest k bits. k is `coll_cnt` clamped into 1..10: a count of 0 counts as 1, and any count of 10 or more gives 10.
- R4: With a captured value v, `done` goes high in the clock cycle that follows the (v*SLOT_LEN+1)-th `bit_en` cycle after the capture cycle. SLOT_LEN defaults to 512.
- R5: A captured value of zero raises `done` after the very next `bit_en` cycle, without waiting a slot.
- R6: `busy` is 1 from the cycle after a capture until the countdown ends. It is 0 in the cycle where `done` is 1.
- R7: A collision pulse that arrives while `busy` is 1 has no effect on the countdown or on the timing of `done`.
- R8: When `clr` is 1 in a cycle, `busy` is 0 in the next cycle and no `done` follows. `clr` also blocks a capture in the same cycle, and it leaves the LFSR sequence unchanged.
- R9: In cycles where `bit_en` is 0, neither the slot prescaler nor the remaining count nor the LFSR moves.
- R10: `done` is high for exactly one clock cycle per completed countdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | One-cycle enable for each bit time |
| coll | input | 1 | Collision report pulse |
| coll_cnt | input | CNT_W (5) | Consecutive collision number; 0 counts as 1 |
| clr | input | 1 | Transmission succeeded: drop any countdown |
| busy | output | 1 | A countdown is running |
| done | output | 1 | One-cycle pulse when the backoff delay has elapsed |

## Verification
The hardest states to reach from the ports are the ones that depend on the exact random value captured: a zero value with the shortest path to `done`, and the longest delays once k is clamped at ten. The bench keeps its own model of the sequence, so it can wait until the low bit it is about to capture is zero, or until the low bits are nonzero, before it pulses the collision input. For the long clamped cases it builds the block with a shortened slot length, so that a full 1023-slot wait fits in the run. Collision pulses repeated through a countdown, including the cycle where `done` fires, together with irregular bit enables, test the ignore and hold rules against a per-cycle model.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
    localparam int LFSR_W = 17;
    localparam int TAP_HI = 17;
    localparam int TAP_LO = 14;
    localparam int K_CAP  = 10;
    typedef logic [LFSR_W-1:0] lfsr_t;
endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr
    import backoff_pkg::*;
#(
    parameter lfsr_t SEED  = lfsr_t'(1),
    parameter int    OUT_W = K_CAP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] low
);
    localparam lfsr_t SEED_OK = (SEED == '0) ? lfsr_t'(1) : SEED;

    lfsr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (adv) begin
            st_d = {st_q[LFSR_W-2:0], st_q[TAP_HI-1] ^ st_q[TAP_LO-1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED_OK;
        else        st_q <= st_d;
    end

    assign low = st_q[OUT_W-1:0];

    a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q != '0);
    a_r9_lfsr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(st_q));
    a_r2_moves: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> st_q != $past(st_q));
endmodule

// File: rtl/backoff_range.sv
module backoff_range #(
    parameter int CNT_W = 5,
    parameter int K_MAX = 10
) (
    input  logic [CNT_W-1:0] cnt,
    output logic [K_MAX-1:0] mask
);
    logic [CNT_W-1:0] k_eff;

    always_comb begin
        if (cnt == '0)                 k_eff = CNT_W'(1);
        else if (cnt > CNT_W'(K_MAX))  k_eff = CNT_W'(K_MAX);
        else                           k_eff = cnt;
    end

    for (genvar i = 0; i < K_MAX; i++) begin : g_bit
        assign mask[i] = (k_eff > CNT_W'(i));
    end

    always_comb begin
        a_r3_mask_nonempty: assert (mask[0] === 1'b1 || $isunknown(cnt));
    end
endmodule

// File: rtl/backoff_count.sv
module backoff_count #(
    parameter int SLOT_LEN = 512,
    parameter int VAL_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             start,
    input  logic [VAL_W-1:0] val,
    input  logic             clr,
    output logic             busy,
    output logic             done
);
    localparam int PRE_W = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SLOT_LEN - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [VAL_W-1:0] rem;
        logic [PRE_W-1:0] pre;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (clr) begin
            st_d.busy = 1'b0;
        end else if (bit_en) begin
            if (start && !st_q.busy) begin
                st_d.busy = 1'b1;
                st_d.rem  = val;
                st_d.pre  = '0;
            end else if (st_q.busy) begin
                if (st_q.rem == '0) begin
                    st_d.done = 1'b1;
                    st_d.busy = 1'b0;
                end else if (st_q.pre == PRE_LAST) begin
                    st_d.pre = '0;
                    st_d.rem = st_q.rem - VAL_W'(1);
                end else begin
                    st_d.pre = st_q.pre + PRE_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.busy && !st_q.done);
    a_r7_keep_running: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && st_q.rem != '0 && !clr |=> st_q.busy);
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy && !bit_en && !clr |=> $stable(st_q.rem) && $stable(st_q.pre) && st_q.busy);
endmodule

// File: rtl/backoff_gen.sv
module backoff_gen
    import backoff_pkg::*;
#(
    parameter int    SLOT_LEN = 512,
    parameter int    CNT_W    = 5,
    parameter lfsr_t SEED     = lfsr_t'(1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             coll,
    input  logic [CNT_W-1:0] coll_cnt,
    input  logic             clr,
    output logic             busy,
    output logic             done
);
    logic [K_CAP-1:0] rnd_low;
    logic [K_CAP-1:0] keep_mask;
    logic [K_CAP-1:0] cap_val;
    logic             start;

    backoff_lfsr #(.SEED(SEED), .OUT_W(K_CAP)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (bit_en),
        .low   (rnd_low)
    );

    backoff_range #(.CNT_W(CNT_W), .K_MAX(K_CAP)) u_range (
        .cnt  (coll_cnt),
        .mask (keep_mask)
    );

    assign cap_val = rnd_low & keep_mask;
    assign start   = coll & bit_en & ~busy & ~clr;

    backoff_count #(.SLOT_LEN(SLOT_LEN), .VAL_W(K_CAP)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .start  (start),
        .val    (cap_val),
        .clr    (clr),
        .busy   (busy),
        .done   (done)
    );

    a_r3_capture_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    a_r5_zero_fast: assert property (@(posedge clk) disable iff (!rst_n)
        start && cap_val == '0 ##1 bit_en && !clr |=> done);
endmodule

// File: tb/backoff_gen_bench.sv
module backoff_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int SLOT       = 16;
    localparam int LIMIT      = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       coll = 1'b0;
    logic [4:0] coll_cnt = '0;
    logic       clr = 1'b0;
    logic       busy, done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit finished = 0;
    string phase = "R1 reset";

    int m_lf = 1;
    int m_busy = 0;
    int m_done = 0;
    int m_rem = 0;
    int m_pre = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    backoff_gen #(.SLOT_LEN(SLOT)) u_backoff_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .coll(coll),
        .coll_cnt(coll_cnt), .clr(clr), .busy(busy), .done(done)
    );

    // behavioural reference, updated at each rising edge
    always @(posedge clk) begin
        int k;
        if (!rst_n) begin
            m_lf = 1; m_busy = 0; m_done = 0; m_rem = 0; m_pre = 0;
        end else begin
            m_done = 0;
            if (clr) begin
                m_busy = 0;
            end else if (bit_en) begin
                if (m_busy == 0 && coll) begin
                    k = (coll_cnt == 0) ? 1 : ((coll_cnt > 10) ? 10 : int'(coll_cnt));
                    m_rem = m_lf % (1 << k);
                    m_pre = 0;
                    m_busy = 1;
                end else if (m_busy != 0) begin
                    if (m_rem == 0) begin
                        m_done = 1; m_busy = 0;
                    end else begin
                        m_pre = m_pre + 1;
                        if (m_pre == SLOT) begin m_pre = 0; m_rem = m_rem - 1; end
                    end
                end
            end
            if (bit_en) m_lf = ((m_lf * 2) % 131072) + (((m_lf / 65536) ^ (m_lf / 8192)) % 2);
        end
    end

    task automatic check(input string tag, input logic act, input int exp);
        total++;
        if (act !== exp[0]) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        check({phase, " busy (R6)"}, busy, m_busy);
        check({phase, " done (R4/R10)"}, done, m_done);
    endtask

    task automatic run_out();
        while (m_busy != 0) begin tick(); end
        repeat (2) tick();
    endtask

    task automatic fire(input int cnt);
        bit_en = 1'b1; coll = 1'b1; coll_cnt = 5'(cnt);
        tick();
        coll = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > LIMIT && !finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cyc, LIMIT);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        check("R1 busy in reset", busy, 0);
        check("R1 done in reset", done, 0);
        rst_n = 1'b1;
        tick();
        check("R1 busy after reset", busy, 0);

        // R3 / R4: first collision, several successive counts with steady enables
        phase = "R3 k=1";  fire(1); run_out();
        phase = "R3 k=2";  fire(2); run_out();
        phase = "R4 k=4";  fire(4); run_out();
        phase = "R3 cnt0"; fire(0); run_out();

        // R5: wait until the captured low bit will be zero
        phase = "R5 zero";
        bit_en = 1'b1;
        while ((m_lf % 2) != 0) tick();
        fire(1);
        tick();
        check("R5 done right after one enable", done, 1);
        repeat (2) tick();

        // R9: sparse enables
        phase = "R9 gaps";
        bit_en = 1'b1; coll = 1'b1; coll_cnt = 5'd5;
        tick();
        coll = 1'b0;
        while (m_busy != 0) begin
            bit_en = ($urandom_range(0, 2) == 0);
            tick();
        end
        bit_en = 1'b1;
        repeat (2) tick();

        // R7: collisions kept high through a countdown and into the done cycle
        phase = "R7 ignore";
        while ((m_lf % 8) == 0) tick();
        fire(3);
        coll = 1'b1;
        while (m_busy != 0) begin
            coll_cnt = 5'($urandom_range(0, 31));
            tick();
        end
        coll = 1'b0;
        repeat (2) tick();

        // R8: success clear mid-countdown, then clear with a collision in the same cycle
        phase = "R8 clear";
        while ((m_lf % 16) == 0) tick();
        fire(4);
        repeat (5) tick();
        clr = 1'b1; tick(); clr = 1'b0;
        check("R8 busy dropped", busy, 0);
        repeat (SLOT * 16 + 4) tick();
        clr = 1'b1; coll = 1'b1; coll_cnt = 5'd1; tick();
        clr = 1'b0; coll = 1'b0;
        check("R8 clear blocks capture", busy, 0);
        repeat (2) tick();
        phase = "R8 after clear"; fire(3); run_out();

        // R3 clamp at ten: count 10 and count 20
        phase = "R3 clamp10"; fire(10); run_out();
        phase = "R3 clamp20"; fire(20); run_out();

        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule